// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next control-memory address of a microprogrammed control unit. It keeps a 7-bit control address register and a single return-address register. Each clock it looks at three fields of the microinstruction now being executed: a branch type, a condition select and an address field. It also looks at the opcode of the instruction that was fetched and at three status bits. From these it loads the next control address.

Four branch types are supported. A jump loads the address field when its condition holds. A call does the same and also saves the address after the call. A return resumes at that saved address. A dispatch converts the 4-bit opcode into the first word of that instruction's routine. A jump or call whose condition fails steps to the next word. The dispatch places every routine on a four-word boundary. This lets a fetch routine end with a dispatch, and lets every memory-reference routine call one shared indirect-address subroutine.

Control memory and the datapath registers are outside this block. Their outputs reach it as plain inputs.

Top module: `mseq_top`

## Requirements
- R1: A synchronous active-high reset sets both the control address and the saved return address to 0. A return taken straight after reset therefore goes to address 0.
- R2: The branch type is a 2-bit code: 00 jump, 01 call, 10 return, 11 dispatch. A jump (00) whose condition holds loads the control address from the address field on the next clock.
- R3: A jump whose condition fails loads the current control address plus one.
- R4: A call (01) whose condition holds loads the address field. It also stores the current control address plus one as the return address.
- R5: A call whose condition fails steps to the current address plus one. The stored return address is left unchanged.
- R6: A return (10) loads the stored return address, whatever the condition select and status bits are.
- R7: A dispatch (11) loads the 7-bit address {0, opcode[3:0], 0, 0}: opcode 0 goes to 0, opcode 1 to 4, opcode 2 to 8 and opcode 15 to 60. The condition is ignored.
- R8: The condition select is a 2-bit code: 00 always true, 01 the indirect bit, 10 the accumulator sign bit, 11 the accumulator zero flag.
- R9: Only one return address is held, so a second call before a return overwrites the first saved address.
- R10: Control-address arithmetic wraps modulo 128. A step from 127 gives 0, and a call taken at 127 saves 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_type | input | 2 | Branch type of the current microinstruction |
| cond_sel | input | 2 | Condition select of the current microinstruction |
| addr_field | input | 7 | Branch target field of the current microinstruction |
| opcode | input | 4 | Opcode of the fetched instruction |
| ind_bit | input | 1 | Indirect-address status bit |
| ac_sign | input | 1 | Accumulator sign bit |
| ac_zero | input | 1 | Accumulator zero flag |
| car | output | 7 | Registered control address |

## Verification
The saved return address can only be seen through a later return, so the hard cases are those where it must be left alone. These are a call whose condition fails, and a jump or dispatch placed between a call and its return. It also has to be overwritten correctly by a nested call. The stimulus reaches these cases by running scripted call/return pairs, with failed calls and nested calls placed before the return. The return then exposes the register's value. It also places the address register at 127 before a step and before a taken call, so the wrap shows up both in the control address and in the saved address. A long pseudo-random run then mixes all codes with a model that tracks both registers.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {
    CS_ALWAYS   = 2'b00,
    CS_INDIRECT = 2'b01,
    CS_SIGN     = 2'b10,
    CS_ZERO     = 2'b11
  } cond_sel_e;

  typedef enum logic [1:0] {
    BT_JUMP     = 2'b00,
    BT_CALL     = 2'b01,
    BT_RETURN   = 2'b10,
    BT_DISPATCH = 2'b11
  } br_type_e;

endpackage

// File: rtl/mseq_cond_eval.sv
module mseq_cond_eval
  import mseq_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ind_bit,
  input  logic       ac_sign,
  input  logic       ac_zero,
  output logic       taken
);

  always_comb begin
    unique case (cond_sel_e'(sel))
      CS_ALWAYS:   taken = 1'b1;
      CS_INDIRECT: taken = ind_bit;
      CS_SIGN:     taken = ac_sign;
      default:     taken = ac_zero;
    endcase
  end

endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch #(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4,
  parameter int SLOT_W = 2
) (
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] entry
);

  localparam int USED_W = OPC_W + SLOT_W;

  // Routine entry = opcode scaled by the slot size; spare upper bits stay 0.
  generate
    if (ADDR_W > USED_W) begin : g_pad
      assign entry = {{(ADDR_W-USED_W){1'b0}}, opcode, {SLOT_W{1'b0}}};
    end else begin : g_fit
      assign entry = {opcode, {SLOT_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/mseq_next_sel.sv
module mseq_next_sel
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [1:0]        br_type,
  input  logic              taken,
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] sbr,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [ADDR_W-1:0] entry,
  output logic [ADDR_W-1:0] car_d,
  output logic              sbr_we,
  output logic [ADDR_W-1:0] sbr_d
);

  logic [ADDR_W-1:0] car_inc;
  assign car_inc = car + ADDR_W'(1);   // wraps modulo 2**ADDR_W
  assign sbr_d   = car_inc;

  always_comb begin
    sbr_we = 1'b0;
    unique case (br_type_e'(br_type))
      BT_JUMP:   car_d = taken ? addr_field : car_inc;
      BT_CALL: begin
        car_d  = taken ? addr_field : car_inc;
        sbr_we = taken;
      end
      BT_RETURN: car_d = sbr;
      default:   car_d = entry;
    endcase
  end

endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        br_type,
  input  logic [1:0]        cond_sel,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              ind_bit,
  input  logic              ac_sign,
  input  logic              ac_zero,
  output logic [ADDR_W-1:0] car
);

  logic              taken;
  logic [ADDR_W-1:0] entry;
  logic [ADDR_W-1:0] car_d;
  logic              sbr_we;
  logic [ADDR_W-1:0] sbr_d;
  logic [ADDR_W-1:0] sbr;

  mseq_cond_eval u_cond (
    .sel     (cond_sel),
    .ind_bit (ind_bit),
    .ac_sign (ac_sign),
    .ac_zero (ac_zero),
    .taken   (taken)
  );

  mseq_dispatch #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .SLOT_W(SLOT_W)) u_disp (
    .opcode (opcode),
    .entry  (entry)
  );

  mseq_next_sel #(.ADDR_W(ADDR_W)) u_next (
    .br_type    (br_type),
    .taken      (taken),
    .car        (car),
    .sbr        (sbr),
    .addr_field (addr_field),
    .entry      (entry),
    .car_d      (car_d),
    .sbr_we     (sbr_we),
    .sbr_d      (sbr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= '0;
      sbr <= '0;
    end else begin
      car <= car_d;
      if (sbr_we) sbr <= sbr_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (car == '0 && sbr == '0)); // R1

  AST_TAKEN_JUMP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BT_JUMP && $past(taken))
      |-> car == $past(addr_field)); // R2

  AST_FALSE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) inside {BT_JUMP, BT_CALL} && !$past(taken))
      |-> car == $past(car) + ADDR_W'(1)); // R3

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BT_CALL && $past(taken))
      |-> sbr == $past(car) + ADDR_W'(1)); // R4

  AST_SBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(br_type) == BT_CALL && $past(taken)))
      |-> $stable(sbr)); // R5

  AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BT_RETURN) |-> car == $past(sbr)); // R6

  AST_DISPATCH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BT_DISPATCH)
      |-> (car[SLOT_W-1:0] == '0 && car[SLOT_W +: OPC_W] == $past(opcode))); // R7

endmodule

// File: tb/mseq_top_tb.sv
module mseq_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] br_type = 2'b00;
  logic [1:0] cond_sel = 2'b00;
  logic [6:0] addr_field = '0;
  logic [3:0] opcode = '0;
  logic       ind_bit = 1'b0;
  logic       ac_sign = 1'b0;
  logic       ac_zero = 1'b0;
  logic [6:0] car;

  int n_run  = 0;
  int n_fail = 0;
  int m_car  = 0;   // model control address
  int m_sbr  = 0;   // model return address

  always #5 clk = ~clk;

  mseq_top u_dut (
    .clk(clk), .rst(rst), .br_type(br_type), .cond_sel(cond_sel),
    .addr_field(addr_field), .opcode(opcode), .ind_bit(ind_bit),
    .ac_sign(ac_sign), .ac_zero(ac_zero), .car(car)
  );

  task automatic check(input string tag, input int exp);
    n_run++;
    if (int'(car) != exp) begin
      n_fail++;
      $display("FAIL %s: car=%0d expected %0d", tag, car, exp);
    end
  endtask

  // One clock: drive on the falling edge, update the model, compare after the rising edge.
  task automatic step(input int bt, input int cs, input int af, input int op,
                      input bit i, input bit s, input bit z, input string tag);
    bit c;
    @(negedge clk);
    br_type = 2'(bt); cond_sel = 2'(cs); addr_field = 7'(af);
    opcode = 4'(op); ind_bit = i; ac_sign = s; ac_zero = z;
    case (cs)
      0: c = 1'b1;
      1: c = i;
      2: c = s;
      default: c = z;
    endcase
    case (bt)
      0: m_car = c ? af : (m_car + 1) % 128;
      1: if (c) begin m_sbr = (m_car + 1) % 128; m_car = af; end
         else m_car = (m_car + 1) % 128;
      2: m_car = m_sbr;
      default: m_car = op * 4;
    endcase
    @(posedge clk);
    #1;
    check(tag, m_car);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired: run did not end");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset address", 0);
    @(negedge clk);
    rst = 1'b0;
    m_car = 0; m_sbr = 0;

    // R1 / R6: return right after reset; false indirect condition must not matter
    step(2, 1, 99, 5, 0, 0, 0, "R1 R6 return after reset");

    // R2: fetch-like sequence starting at 64, stepping with NEXT targets
    step(0, 0, 64, 0, 0, 0, 0, "R2 jump always");
    step(0, 0, 65, 0, 0, 0, 0, "R2 jump next");
    step(0, 0, 66, 0, 0, 0, 0, "R2 jump next");

    // R7: dispatch of several opcodes, condition set false
    step(3, 1, 99, 0, 0, 0, 0, "R7 opcode 0");
    step(3, 2, 99, 1, 0, 0, 0, "R7 opcode 1");
    step(3, 3, 99, 2, 0, 0, 0, "R7 opcode 2");
    step(3, 0, 99, 15, 0, 0, 0, "R7 opcode 15");

    // R4 / R6: indirect call from routine word 0 to a shared subroutine at 67
    step(3, 0, 0, 0, 0, 0, 0, "R7 back to opcode 0");
    step(1, 1, 67, 0, 1, 0, 0, "R4 call on indirect");
    step(0, 0, 68, 0, 0, 0, 0, "R2 subroutine next");
    step(2, 0, 0, 0, 0, 0, 0, "R6 return to word 1");

    // R5: failed call keeps saved address; a return exposes it
    step(1, 1, 90, 0, 0, 0, 0, "R5 call condition false");
    step(0, 2, 30, 0, 0, 0, 0, "R3 jump sign false");
    step(2, 3, 0, 0, 0, 0, 1, "R5 R6 return after failed call");

    // R8: each condition code both ways
    step(0, 2, 40, 0, 0, 1, 0, "R8 sign true");
    step(0, 2, 10, 0, 1, 0, 1, "R8 sign false");
    step(0, 3, 50, 0, 0, 0, 1, "R8 zero true");
    step(0, 3, 10, 0, 1, 1, 0, "R8 zero false");
    step(0, 1, 70, 0, 1, 0, 0, "R8 indirect true");
    step(0, 1, 10, 0, 0, 1, 1, "R8 indirect false");

    // R9: nested calls overwrite the single return register
    step(1, 0, 20, 0, 0, 0, 0, "R9 first call");
    step(1, 0, 40, 0, 0, 0, 0, "R9 nested call");
    step(2, 0, 0, 0, 0, 0, 0, "R9 return to inner");
    step(2, 0, 0, 0, 0, 0, 0, "R9 return repeats");

    // R10: wrap of step and of saved address
    step(0, 0, 127, 0, 0, 0, 0, "R10 jump to 127");
    step(0, 1, 5, 0, 0, 0, 0, "R10 step wraps");
    step(0, 0, 127, 0, 0, 0, 0, "R10 jump to 127");
    step(1, 0, 10, 0, 0, 0, 0, "R10 call at 127");
    step(2, 0, 0, 0, 0, 0, 0, "R10 return to 0");

    // Mixed run covering all codes against the model
    for (int k = 0; k < 400; k++) begin
      step(int'($urandom_range(3)), int'($urandom_range(3)),
           int'($urandom_range(127)), int'($urandom_range(15)),
           1'($urandom), 1'($urandom), 1'($urandom), "R2-mix R3 R4 R5 R6 R7 R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule